// File: doc/BRIEF.md
# Shared-Prescaler Timer/Counter

This block is an 8-bit timer/counter that software can read and load. It counts one of two event sources. The first is the instruction-cycle enable, which is internal. The second is edges on an external clock pin, taken on either the rising or the falling edge. When the count wraps from 0xFF to 0x00, a sticky overflow flag is set. A single 8-bit prescaler sits beside the counter. It can slow the counter down, or it can instead divide the tick stream that a separate watchdog counter consumes. It never serves both at once.

A 6-bit control word configures the block:

| Bit | Function |
|-----|----------|
| cfg[5] | 0 counts instruction cycles, 1 counts pin edges |
| cfg[4] | 0 selects rising pin edges, 1 selects falling pin edges |
| cfg[3] | 0 gives the prescaler to the counter, 1 gives it to the watchdog path |
| cfg[2:0] | ratio code N |

A load through the write port holds off counting for the next two instruction cycles. The internal prescaler count is never visible at the ports.

Top module: `cyc_timer`

## Requirements
- R1: A synchronous reset clears the count, the overflow flag and the watchdog tick output.
- R2: With cfg[5]=0 and cfg[3]=1, the count rises by one for each clock in which `ce` is high, once the hold-off from R5 has ended. It does not change while `ce` is low.
- R3: With cfg[5]=1, a change on `ext_clk` reaches the count after the third rising clock edge. cfg[4]=0 counts only rising pin edges and cfg[4]=1 counts only falling pin edges.
- R4: A write sets `rd_data` to `wr_data` on the next clock. A write wins over an increment in the same cycle.
- R5: After a write, the next two clocks with `ce` high produce no increment, whatever the source is.
- R6: With cfg[3]=0, the count advances once per 2^(N+1) source events.
- R7: With cfg[3]=1, the count advances on every source event. `wdt_tick_out` pulses once per 2^N `wdt_tick_in` pulses, one clock after the pulse that completes the group.
- R8: With cfg[3]=0, a write clears the prescaler count, so a full group of 2^(N+1) events must pass after the hold-off.
- R9: With cfg[3]=1, a `wdt_clr` pulse clears the prescaler count. A `wdt_tick_in` pulse in the same cycle is discarded.
- R10: A wrap from 0xFF to 0x00 sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed. A wrap in the same cycle as `ovf_clr` leaves the flag set.
- R11: With cfg[3]=0, `wdt_tick_out` equals `wdt_tick_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Instruction-cycle enable |
| ext_clk | input | 1 | External count pin, asynchronous |
| cfg | input | 6 | Control word as in the table above |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 8 | Value to load |
| rd_data | output | 8 | Current count |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog-clear strobe |
| wdt_tick_in | input | 1 | Raw watchdog tick |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick_out | output | 1 | Watchdog tick after scaling, registered |

## Verification
Directed sequences cover each case separately:
- A steady `ce` stream near 0xFF separates the hold-off from the wrap.
- A 1:4 timer ratio, with a load made while the prescaler is part-way through a group, shows whether the load really clears the hidden prescaler.
- A continuous watchdog tick train, broken by a clear, tells division apart from a missed clear.
- Pin toggles under both edge settings tell rising from falling and measure the synchronizer latency.

Seeded random traffic on every input, including control-word changes while counting, is then compared cycle by cycle against a reference model in the bench.

// File: rtl/cyc_timer_pkg.sv
`timescale 1ns/1ps
package cyc_timer_pkg;
  // Owner of the shared prescaler, decoded from the assignment bit.
  typedef enum logic {
    OWN_TIMER = 1'b0,
    OWN_WDT   = 1'b1
  } pre_owner_t;

  // Source of counter events, decoded from the source bit.
  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } src_sel_t;
endpackage

// File: rtl/cyc_timer_insync.sv
`timescale 1ns/1ps
// Brings the asynchronous pin into the clock domain and detects the chosen edge.
module cyc_timer_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_ev
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[TOP];
    end
  end

  always_comb begin
    if (fall_sel) edge_ev = prev & ~chain[TOP];
    else          edge_ev = chain[TOP] & ~prev;
  end

  // R3: an edge event lasts a single cycle unless the polarity was switched
  p_edge_gap_r3: assert property (@(posedge clk) disable iff (rst)
    edge_ev |=> (!edge_ev || fall_sel != $past(fall_sel)));
endmodule

// File: rtl/cyc_timer_prescale.sv
`timescale 1ns/1ps
// Shared prescaler; the division span depends on which path owns it.
module cyc_timer_prescale #(
  parameter int PRE_W = 8,
  parameter int RAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             to_wdt,
  input  logic [RAT_W-1:0] ratio,
  input  logic             ev,
  input  logic             clr,
  output logic             tick
);
  localparam logic [PRE_W:0] ONE = (PRE_W+1)'(1);

  logic [PRE_W-1:0] cnt;
  logic [RAT_W:0]   shamt;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;

  always_comb begin
    // Counter path divides by 2^(N+1), watchdog path by 2^N.
    shamt = {1'b0, ratio} + {{RAT_W{1'b0}}, ~to_wdt};
    span  = (ONE << shamt) - ONE;
    mask  = span[PRE_W-1:0];
    tick  = ev && !clr && ((cnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (ev)  cnt <= cnt + PRE_W'(1);
  end

  // R8/R9: after a clear, only a 1:1 span can tick in the next cycle
  p_clr_restart_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!tick || mask == '0));
endmodule

// File: rtl/cyc_timer_core.sv
`timescale 1ns/1ps
// Count register, overflow flag and the hold-off window that follows a load.
module cyc_timer_core #(
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             inc,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             hold
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] hold_cnt;

  assign hold = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
    end else if (wr_en) begin
      hold_cnt <= HW'(HOLD_CYC);
    end else if (ce && hold) begin
      hold_cnt <= hold_cnt - HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_en) begin
      cnt <= wr_data;
    end else if (inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // A wrap sets the flag and wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
    end else if (!wr_en && inc && (&cnt)) begin
      ovf <= 1'b1;
    end else if (ovf_clr) begin
      ovf <= 1'b0;
    end
  end

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt == $past(wr_data));

  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_en) |=> cnt == $past(cnt));

  p_ovf_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr_en && cnt == '1) |=> (ovf && cnt == '0));
endmodule

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
module cyc_timer
  import cyc_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int RAT_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             ext_clk,
  input  logic [RAT_W+2:0] cfg,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ovf_clr,
  input  logic             wdt_clr,
  input  logic             wdt_tick_in,
  output logic             ovf_flag,
  output logic             wdt_tick_out
);
  src_sel_t         src;
  pre_owner_t       owner;
  logic             fall_sel;
  logic [RAT_W-1:0] ratio;

  assign src      = src_sel_t'(cfg[RAT_W+2]);
  assign fall_sel = cfg[RAT_W+1];
  assign owner    = pre_owner_t'(cfg[RAT_W]);
  assign ratio    = cfg[RAT_W-1:0];

  logic pin_ev, src_ev, run_ev, hold;
  logic pre_ev, pre_clr, pre_tick, inc;

  cyc_timer_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_clk), .fall_sel(fall_sel), .edge_ev(pin_ev)
  );

  always_comb begin
    src_ev  = (src == SRC_PIN) ? pin_ev : ce;
    run_ev  = src_ev && !hold && !wr_en;
    pre_ev  = (owner == OWN_WDT) ? wdt_tick_in : run_ev;
    pre_clr = (owner == OWN_WDT) ? wdt_clr     : wr_en;
    inc     = (owner == OWN_WDT) ? run_ev      : pre_tick;
  end

  cyc_timer_prescale #(.PRE_W(PRE_W), .RAT_W(RAT_W)) u_pre (
    .clk(clk), .rst(rst), .to_wdt(owner == OWN_WDT), .ratio(ratio),
    .ev(pre_ev), .clr(pre_clr), .tick(pre_tick)
  );

  cyc_timer_core #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_core (
    .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_data(wr_data),
    .inc(inc), .ovf_clr(ovf_clr), .cnt(rd_data), .ovf(ovf_flag), .hold(hold)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_tick_out <= 1'b0;
    else     wdt_tick_out <= (owner == OWN_WDT) ? pre_tick : wdt_tick_in;
  end

  // R11: with the prescaler on the counter, the watchdog tick passes through
  p_wdt_bypass_r11: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_TIMER) |=> wdt_tick_out == $past(wdt_tick_in));
endmodule

// File: tb/cyc_timer_tb.sv
`timescale 1ns/1ps
module cyc_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0, ext_clk = 1'b0, wr_en = 1'b0;
  logic [5:0] cfg = 6'b001000;
  logic [7:0] wr_data = 8'h00;
  logic       ovf_clr = 1'b0, wdt_clr = 1'b0, wdt_tick_in = 1'b0;
  logic [7:0] rd_data;
  logic       ovf_flag, wdt_tick_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_tmr = 0, m_pcnt = 0, m_inh = 0;
  bit m_ovf = 0, m_wdo = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;

  always #2 clk = ~clk;

  cyc_timer u_dut (
    .clk(clk), .rst(rst), .ce(ce), .ext_clk(ext_clk), .cfg(cfg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ovf_clr(ovf_clr),
    .wdt_clr(wdt_clr), .wdt_tick_in(wdt_tick_in), .ovf_flag(ovf_flag),
    .wdt_tick_out(wdt_tick_out)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit rise, fall, eext, src, run, pev, pclr, ptick, inc, own;
    int mask;
    if (rst) begin
      m_tmr = 0; m_pcnt = 0; m_inh = 0; m_ovf = 0; m_wdo = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      return;
    end
    own  = cfg[3];
    rise = m_s2 && !m_prev;
    fall = !m_s2 && m_prev;
    eext = cfg[4] ? fall : rise;
    src  = cfg[5] ? eext : ce;
    run  = src && (m_inh == 0) && !wr_en;
    pev  = own ? wdt_tick_in : run;
    pclr = own ? wdt_clr : wr_en;
    mask = (1 << (int'(cfg[2:0]) + (own ? 0 : 1))) - 1;
    ptick = pev && !pclr && ((m_pcnt & mask) == mask);
    inc  = own ? run : ptick;
    m_wdo = own ? ptick : wdt_tick_in;
    if (pclr) m_pcnt = 0; else if (pev) m_pcnt = (m_pcnt + 1) & 255;
    if (!wr_en && inc && m_tmr == 255) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    if (wr_en) m_tmr = wr_data; else if (inc) m_tmr = (m_tmr + 1) & 255;
    if (wr_en) m_inh = 2; else if (ce && m_inh != 0) m_inh--;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
  endtask

  task automatic step();
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load(logic [7:0] v);
    wr_en = 1'b1; wr_data = v; step(); wr_en = 1'b0;
  endtask

  initial begin
    int pulses;
    void'($urandom(32'd4242));
    @(negedge clk);
    steps(3);
    rst = 1'b0;
    chk("R1 count", rd_data, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 wdt", wdt_tick_out, 0);

    // internal source, prescaler on watchdog path, ratio 1:1
    cfg = 6'b001000; ce = 1'b1;
    load(8'hFE);
    chk("R4 load", rd_data, 8'hFE);
    step(); chk("R5 hold1", rd_data, 8'hFE);
    step(); chk("R5 hold2", rd_data, 8'hFE);
    step(); chk("R2 inc", rd_data, 8'hFF);
    step(); chk("R10 wrap", rd_data, 8'h00); chk("R10 flag set", ovf_flag, 1);
    ce = 1'b0; steps(2);
    chk("R2 idle", rd_data, 8'h00); chk("R10 sticky", ovf_flag, 1);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R10 clear", ovf_flag, 0);
    ce = 1'b1;
    load(8'hFF); steps(2);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R10 set wins", ovf_flag, 1);
    chk("R10 wrap value", rd_data, 8'h00);

    // prescaler on the counter, ratio code 1 -> 1:4
    cfg = 6'b000001;
    load(8'h10);
    steps(5); chk("R6 before group", rd_data, 8'h10);
    step();   chk("R6 after group", rd_data, 8'h11);
    steps(2);
    load(8'h20);
    steps(5); chk("R8 prescaler cleared", rd_data, 8'h20);
    step();   chk("R8 full group", rd_data, 8'h21);

    // prescaler on watchdog path, ratio code 2 -> 1:4
    cfg = 6'b001010;
    load(8'h40); steps(2); steps(5);
    chk("R7 direct count", rd_data, 8'h45);
    ce = 1'b0;
    wdt_clr = 1'b1; step(); wdt_clr = 1'b0;
    wdt_tick_in = 1'b1; pulses = 0;
    for (int i = 0; i < 16; i++) begin step(); pulses += wdt_tick_out; end
    chk("R7 wdt division", pulses, 4);
    pulses = 0;
    for (int i = 0; i < 3; i++) begin step(); pulses += wdt_tick_out; end
    wdt_tick_in = 1'b0; wdt_clr = 1'b1; step(); wdt_clr = 1'b0;
    pulses += wdt_tick_out;
    wdt_tick_in = 1'b1;
    for (int i = 0; i < 3; i++) begin step(); pulses += wdt_tick_out; end
    chk("R9 cleared", pulses, 0);
    step(); chk("R9 group after clear", wdt_tick_out, 1);
    wdt_tick_in = 1'b0; step();

    // external pin, rising then falling
    cfg = 6'b101000; ext_clk = 1'b0; ce = 1'b1;
    load(8'h80); steps(2); ce = 1'b0;
    ext_clk = 1'b1; steps(2); chk("R3 latency", rd_data, 8'h80);
    step(); chk("R3 rising", rd_data, 8'h81);
    ext_clk = 1'b0; steps(4); chk("R3 falling ignored", rd_data, 8'h81);
    cfg = 6'b111000;
    ext_clk = 1'b1; steps(4); chk("R3 rising ignored", rd_data, 8'h81);
    ext_clk = 1'b0; steps(2); chk("R3 latency fall", rd_data, 8'h81);
    step(); chk("R3 falling", rd_data, 8'h82);

    // watchdog bypass
    cfg = 6'b000000;
    wdt_tick_in = 1'b1; step(); chk("R11 pass high", wdt_tick_out, 1);
    wdt_tick_in = 1'b0; step(); chk("R11 pass low", wdt_tick_out, 0);

    // random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) == 0) cfg = 6'($urandom);
      ce          = ($urandom_range(1) == 0);
      wr_en       = ($urandom_range(19) == 0);
      wr_data     = 8'($urandom);
      ovf_clr     = ($urandom_range(19) == 0);
      wdt_clr     = ($urandom_range(19) == 0);
      wdt_tick_in = ($urandom_range(9) < 4);
      if ($urandom_range(9) < 3) ext_clk = ~ext_clk;
      step();
      chk("R6 R7 model count", rd_data, m_tmr);
      chk("R10 model flag", ovf_flag, m_ovf);
      chk("R7 R11 model wdt", wdt_tick_out, m_wdo);
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule